// File: doc/BRIEF.md
# MII Management Pin Multiplexer

This block stands between an MDIO frame engine and the two shared management pads: the clock pad and the bidirectional data pad. A single control register chooses who owns those pads. When the engine owns them, its clock, data-out and data-enable reach the pads through one register stage. In bypass mode, software toggles a clock bit, a direction bit and a data bit to bit-bang the interface by hand.

The same register reads back the pad state. The data bit returns the synchronised level of the data pad in either mode. A PHY-present flag reads 1 while the management data line sits high, which happens when a PHY's pull-up holds it there. Two more register bits leave the block on their own pins: one drives an external enable pin, and the other selects the 7-wire serial MII mode for 10 Mbps serial PHYs. A link input pin is synchronised and can be read back. When ownership moves from one side to the other, the data output enable drops for one clock so that the two drivers never overlap.

Top module: `mdio_pin_mux`

## Requirements
- R1: After reset, register bit 0 (engine owns pads) reads 1. Bits 1 (bypass clock), 2 (bypass direction, 1 = output), 4 (enable pin) and 5 (serial mode) read 0. All pad outputs are 0.
- R2: While bit 0 is 1, pad_mdc, pad_mdo and pad_mdo_en equal eng_mdc, eng_mdo and eng_mdo_en as sampled at the previous clock edge.
- R3: While bit 0 is 0, pad_mdc equals register bit 1 as it stood at the previous clock edge.
- R4: While bit 0 is 0, pad_mdo_en equals register bit 2 and pad_mdo equals the last value written to bit 3, both taken one clock later. When bit 2 is 0, the data pad is not driven.
- R5: Read bit 3 returns pad_mdi delayed by two flops, whatever the mode. The value written to bit 3 never shows on the read path.
- R6: Read bit 6 (PHY present) is 1 exactly when the synchronised data pad level is 1. Writes to bit 6 have no effect.
- R7: Read bit 7 returns link_in delayed by two flops. Writes to bit 7 have no effect. The output ext_en equals register bit 4.
- R8: The output serial_mode equals register bit 5.
- R9: On the clock after bit 0 changes value, pad_mdo_en is 0 whatever either side requests.
- R10: eng_mdi returns pad_mdi delayed by two flops, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read-back: control bits, data pad level, PHY present, link |
| eng_mdc | input | 1 | Management clock from the frame engine |
| eng_mdo | input | 1 | Data out from the frame engine |
| eng_mdo_en | input | 1 | Data output enable from the frame engine |
| eng_mdi | output | 1 | Synchronised data pad level to the frame engine |
| pad_mdc | output | 1 | Management clock pad |
| pad_mdo | output | 1 | Data pad output value |
| pad_mdo_en | output | 1 | Data pad output enable |
| pad_mdi | input | 1 | Data pad input level |
| link_in | input | 1 | External link status pin |
| ext_en | output | 1 | External enable pin |
| serial_mode | output | 1 | 7-wire serial MII mode select |

## Verification
The bench goes after the ownership hand-over. If the one-cycle blanking were missing, pad_mdo_en would stay high straight through the switch, and the two drivers would contend for the pad. It writes a 1 to the data bit while the pad sits low. A design that read back the stored value instead of the pad level would return 1 and would also report a PHY that is absent. It also writes to the read-only bits and varies the pad and link inputs one cycle at a time. A synchroniser with the wrong depth, or a bypass path that ignored the direction bit, then shows a value one cycle early or late, or drives the pad while it should be an input.

// File: rtl/mdio_pin_mux_pkg.sv
package mdio_pin_mux_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_OWN   = 0;
  localparam int unsigned B_CLK   = 1;
  localparam int unsigned B_DIR   = 2;
  localparam int unsigned B_DATA  = 3;
  localparam int unsigned B_EXTEN = 4;
  localparam int unsigned B_SER   = 5;
  localparam int unsigned B_PHY   = 6;
  localparam int unsigned B_LINK  = 7;

  typedef struct packed {
    logic serial_mode;
    logic ext_en;
    logic bb_dout;
    logic bb_oe;
    logic bb_clk;
    logic eng_own;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{serial_mode: 1'b0, ext_en: 1'b0, bb_dout: 1'b0,
                                   bb_oe: 1'b0, bb_clk: 1'b0, eng_own: 1'b1};

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[LAST];
endmodule

// File: rtl/mdio_ctrl_regs.sv
module mdio_ctrl_regs
  import mdio_pin_mux_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl
);
  logic unused_ro;
  assign unused_ro = wdata[B_PHY] ^ wdata[B_LINK];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RESET;
    end else if (we) begin
      ctrl.eng_own     <= wdata[B_OWN];
      ctrl.bb_clk      <= wdata[B_CLK];
      ctrl.bb_oe       <= wdata[B_DIR];
      ctrl.bb_dout     <= wdata[B_DATA];
      ctrl.ext_en      <= wdata[B_EXTEN];
      ctrl.serial_mode <= wdata[B_SER];
    end
  end
endmodule

// File: rtl/mdio_pad_mux.sv
module mdio_pad_mux
  import mdio_pin_mux_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  eng_mdc,
  input  logic  eng_mdo,
  input  logic  eng_mdo_en,
  output logic  pad_mdc,
  output logic  pad_mdo,
  output logic  pad_mdo_en
);
  logic own_d1;
  logic handover;
  logic mdc_nx, mdo_nx, oe_nx;

  assign handover = ctrl.eng_own ^ own_d1;

  always_comb begin
    if (ctrl.eng_own) begin
      mdc_nx = eng_mdc;
      mdo_nx = eng_mdo;
      oe_nx  = eng_mdo_en;
    end else begin
      mdc_nx = ctrl.bb_clk;
      mdo_nx = ctrl.bb_dout;
      oe_nx  = ctrl.bb_oe;
    end
    if (handover) oe_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_d1     <= CTRL_RESET.eng_own;
      pad_mdc    <= 1'b0;
      pad_mdo    <= 1'b0;
      pad_mdo_en <= 1'b0;
    end else begin
      own_d1     <= ctrl.eng_own;
      pad_mdc    <= mdc_nx;
      pad_mdo    <= mdo_nx;
      pad_mdo_en <= oe_nx;
    end
  end
endmodule

// File: rtl/mdio_pin_mux.sv
module mdio_pin_mux
  import mdio_pin_mux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             eng_mdc,
  input  logic             eng_mdo,
  input  logic             eng_mdo_en,
  output logic             eng_mdi,
  output logic             pad_mdc,
  output logic             pad_mdo,
  output logic             pad_mdo_en,
  input  logic             pad_mdi,
  input  logic             link_in,
  output logic             ext_en,
  output logic             serial_mode
);
  localparam int unsigned SYNC_W = 2;

  ctrl_t             ctrl;
  logic [SYNC_W-1:0] sync_q;
  logic              mdi_s, link_s;

  mdio_ctrl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .ctrl  (ctrl)
  );

  mdio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({link_in, pad_mdi}),
    .q   (sync_q)
  );

  assign mdi_s  = sync_q[0];
  assign link_s = sync_q[1];

  mdio_pad_mux u_pads (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .eng_mdc    (eng_mdc),
    .eng_mdo    (eng_mdo),
    .eng_mdo_en (eng_mdo_en),
    .pad_mdc    (pad_mdc),
    .pad_mdo    (pad_mdo),
    .pad_mdo_en (pad_mdo_en)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_OWN]   = ctrl.eng_own;
    reg_rdata[B_CLK]   = ctrl.bb_clk;
    reg_rdata[B_DIR]   = ctrl.bb_oe;
    reg_rdata[B_DATA]  = mdi_s;
    reg_rdata[B_EXTEN] = ctrl.ext_en;
    reg_rdata[B_SER]   = ctrl.serial_mode;
    reg_rdata[B_PHY]   = mdi_s;
    reg_rdata[B_LINK]  = link_s;
  end

  assign eng_mdi     = mdi_s;
  assign ext_en      = ctrl.ext_en;
  assign serial_mode = ctrl.serial_mode;
endmodule

// File: rtl/mdio_pin_mux_chk.sv
module mdio_pin_mux_chk
  import mdio_pin_mux_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             eng_mdc,
  input logic             eng_mdo,
  input logic             eng_mdo_en,
  input logic             eng_mdi,
  input logic             pad_mdc,
  input logic             pad_mdo,
  input logic             pad_mdo_en,
  input logic             pad_mdi,
  input logic             link_in,
  input logic             ext_en,
  input logic             serial_mode
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)            cyc <= '0;
    else if (cyc != 3)  cyc <= cyc + 2'd1;
  end

  p_reset_own_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reg_rdata[B_OWN] && !ext_en && !serial_mode && !pad_mdo_en));

  p_engine_clk_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[B_OWN] |=> (pad_mdc == $past(eng_mdc)));

  p_bypass_clk_r3: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[B_OWN] |=> (pad_mdc == $past(reg_rdata[B_CLK])));

  p_bypass_input_r4: assert property (@(posedge clk) disable iff (rst)
    (!reg_rdata[B_OWN] && !reg_rdata[B_DIR]) |=> !pad_mdo_en);

  p_data_sync_r5: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2) |-> (reg_rdata[B_DATA] == $past(pad_mdi, 2)));

  p_phy_present_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[B_PHY] == reg_rdata[B_DATA]);

  p_link_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2) |-> (reg_rdata[B_LINK] == $past(link_in, 2)));

  p_handover_gap_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_rdata[B_OWN]) |=> !pad_mdo_en);

  p_engine_in_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2) |-> (eng_mdi == $past(pad_mdi, 2)));
endmodule

bind mdio_pin_mux mdio_pin_mux_chk u_chk (.*);

// File: tb/mdio_pin_mux_test.sv
module mdio_pin_mux_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       eng_mdc = 0, eng_mdo = 0, eng_mdo_en = 0, eng_mdi;
  logic       pad_mdc, pad_mdo, pad_mdo_en;
  logic       pad_mdi = 0, link_in = 0;
  logic       ext_en, serial_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit live     = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  mdio_pin_mux uut (.*);

  // behavioural reference state
  bit m_own = 1, m_own_prev = 1, m_clk = 0, m_dir = 0, m_dout = 0, m_en = 0, m_ser = 0;
  bit m_mdc = 0, m_mdo = 0, m_oe = 0;
  bit mdi_q[$] = '{0, 0};
  bit lnk_q[$] = '{0, 0};

  always @(posedge clk) begin
    if (rst) begin
      m_own = 1; m_own_prev = 1; m_clk = 0; m_dir = 0; m_dout = 0; m_en = 0; m_ser = 0;
      m_mdc = 0; m_mdo = 0; m_oe = 0;
      mdi_q = '{0, 0};
      lnk_q = '{0, 0};
    end else begin
      m_mdc = m_own ? eng_mdc : m_clk;
      m_mdo = m_own ? eng_mdo : m_dout;
      m_oe  = (m_own != m_own_prev) ? 1'b0 : (m_own ? eng_mdo_en : m_dir);
      m_own_prev = m_own;
      if (reg_we) begin
        m_own = reg_wdata[0]; m_clk = reg_wdata[1]; m_dir = reg_wdata[2];
        m_dout = reg_wdata[3]; m_en = reg_wdata[4]; m_ser = reg_wdata[5];
      end
      mdi_q.push_back(pad_mdi); void'(mdi_q.pop_front());
      lnk_q.push_back(link_in); void'(lnk_q.pop_front());
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      check("R1 owner bit", reg_rdata[0], m_own);
      check("R3 clock bit", reg_rdata[1], m_clk);
      check("R4 direction bit", reg_rdata[2], m_dir);
      check("R5 data readback", reg_rdata[3], mdi_q[0]);
      check("R6 phy present", reg_rdata[6], mdi_q[0]);
      check("R7 link readback", reg_rdata[7], lnk_q[0]);
      check("R7 enable pin", ext_en, m_en);
      check("R8 serial mode", serial_mode, m_ser);
      check("R10 engine data in", eng_mdi, mdi_q[0]);
      check(m_own_prev ? "R2 pad clock" : "R3 pad clock", pad_mdc, m_mdc);
      check(m_own_prev ? "R2 pad data" : "R4 pad data", pad_mdo, m_mdo);
      check("R9 R2 R4 pad enable", pad_mdo_en, m_oe);
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_we = 1; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    check("R1 reset rdata", reg_rdata, 8'h01);
    check("R1 reset pads", {pad_mdc, pad_mdo, pad_mdo_en}, 3'b000);
    rst = 0;
    live = 1;
    // engine owns pads, drive engine with enable high
    eng_mdc = 1; eng_mdo = 1; eng_mdo_en = 1; pad_mdi = 1;
    idle(4);
    // hand-over to bypass, output direction, clock high, data 1 (R9 blanking)
    wr(8'b0000_1110);
    idle(3);
    // pad low while data bit written 1: readback must show pad (R5, R6)
    pad_mdi = 0;
    wr(8'b1100_1100);
    idle(4);
    // bypass as input (R4)
    wr(8'b0011_0010);
    link_in = 1;
    idle(4);
    // back to engine (R9)
    wr(8'b0000_0101);
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      eng_mdc = $urandom(); eng_mdo = $urandom(); eng_mdo_en = $urandom();
      pad_mdi = $urandom(); link_in = $urandom();
      if ($urandom_range(0, 5) == 0) begin
        reg_we = 1; reg_wdata = 8'($urandom());
      end else begin
        reg_we = 0;
      end
    end
    @(negedge clk);
    reg_we = 0;
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule